// File: doc/BRIEF.md
# Serial PCM Voice Data Port

This block is the digital serial port of a voice codec. It moves 13-bit linear PCM samples in both directions at once. Its bit clocks and frame syncs come from off-chip, and it oversamples them on a fast system clock. The transmit side loads a parallel sample at the start of each frame and shifts it out MSB first on the transmit bit clock. The transmit frame sync marks the start of the frame. The receive side shifts in a word on the falling edges of its bit clock and presents it in parallel with a one-cycle strobe. The receive frame sync need not be aligned to the transmit one.

Frame timing is recognised from the width of the sync pulse, measured in bit clocks. A pulse one bit clock wide is short-frame timing, and the first bit follows it. A wider pulse is long-frame timing, and the first bit starts with the sync rising edge. The receive bit clock input also acts as a mode strap. If it stays still for several frames, receive data is taken on the transmit bit clock. Its resting level then picks one of two 16-bit layouts. Level 0 gives sign-extended words. Level 1 gives a 13-bit sample followed by a 3-bit receive attenuation code.

Top module: `pcm_voice_port`

## Requirements
- R1: After reset, tx_oe, tx_dout and rx_valid are 0 and port_mode is 0 (asynchronous mode).
- R2: With a sync pulse exactly one bit clock wide, transmit bit 0 occupies the bit period after the one in which the sync was high. Bits leave MSB first, one per transmit bit-clock rising edge. Asynchronous mode and gain-adjust mode send 13 bits.
- R3: A sync pulse wider than one bit clock selects long timing, where bit 0 starts at the sync rising edge. Long timing is taken from the width measured on the previous frame. So the first long frame after reset or after short frames is only measured: no transmit bits, no receive strobe.
- R4: tx_oe is 1 exactly during the transmitted bit periods, and tx_dout is 0 whenever tx_oe is 0.
- R5: In asynchronous mode, the receive side takes 13 bits MSB first on falling edges of rx_bclk. One cycle after the last bit, it pulses rx_valid for one cycle with the word on rx_sample and rx_atten = 0.
- R6: After 4 consecutive rx_fsync rising edges with no rx_bclk edge, the port enters a synchronous mode: port_mode = 1 if rx_bclk rests at 0, and 2 if it rests at 1. Any rx_bclk edge returns port_mode to 0.
- R7: In sign-extended mode (port_mode 1), receive bits are clocked by tx_bclk. Transfers are 16 bits: the transmit word's first four bits all equal the sample sign, and rx_sample is the last 13 received bits.
- R8: In gain-adjust mode (port_mode 2), transmit sends 13 bits. Receive takes 16 bits on tx_bclk: the first 13 go to rx_sample and the last 3 go to rx_atten, MSB first.
- R9: The receive frame may start in a different bit period from the transmit frame without affecting either direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clocks |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_bclk | input | 1 | Transmit bit clock |
| tx_fsync | input | 1 | Transmit frame sync |
| tx_sample | input | 13 | Sample to send, captured at frame start |
| tx_dout | output | 1 | Serial transmit data |
| tx_oe | output | 1 | Output enable for the transmit data pad |
| rx_bclk | input | 1 | Receive bit clock, also the mode strap when idle |
| rx_fsync | input | 1 | Receive frame sync |
| rx_din | input | 1 | Serial receive data |
| rx_sample | output | 13 | Last received sample |
| rx_atten | output | 3 | Last received attenuation code (gain-adjust mode only) |
| rx_valid | output | 1 | One-cycle strobe for rx_sample and rx_atten |
| port_mode | output | 2 | 0 asynchronous, 1 sign-extended, 2 gain-adjust |

## Verification
The bench goes after the corners where a frame starts, ends or changes meaning. It offsets the receive frame from the transmit one, so a port that framed receive from the transmit sync would shift the captured word. It checks the first long frame after short ones: a design that trusted a stale width would start transmitting mid-frame. It counts idle frames to the exact boundary, so an off-by-one counter would report a synchronous mode one frame early or late. It also checks both strap levels for word length and field order. Taking the attenuation bits from the front of the word, or padding instead of sign-extending, would garble rx_sample or the transmit pattern.

// File: rtl/pcm_port_pkg.sv
// Shared widths and the port mode encoding for the serial PCM port.
package pcm_port_pkg;
    localparam int SAMPLE_W = 13;                 // linear PCM sample
    localparam int WORD_W   = 16;                 // longest serial word
    localparam int ATTEN_W  = WORD_W - SAMPLE_W;  // gain-control field / sign pad
    localparam int CNT_W    = $clog2(WORD_W + 1);

    // Encoding is visible on port_mode and is part of the interface.
    typedef enum logic [1:0] {
        PORT_ASYNC   = 2'd0,
        PORT_SIGNEXT = 2'd1,
        PORT_GAINADJ = 2'd2
    } port_mode_e;
endpackage

// File: rtl/pcm_input_sync.sv
// Multi-stage synchronizer for a vector of slow asynchronous inputs.
// Assumes each input holds for many system clocks between changes, so
// all lines see the same latency of STAGES cycles.
module pcm_input_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    // Shift the raw inputs through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= '0;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/pcm_frame_timing.sv
// Frame start detector for one direction. It measures the sync pulse width
// in bit clocks (sampled on bit-clock rises). A width of one gives a short
// frame start on the following bit-clock rise. A longer width sets long
// timing for later frames, which start on the sync rising edge.
// Assumes the sync changes together with a bit-clock rising edge.
module pcm_frame_timing #(
    parameter int WCNT_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_rise,
    input  logic fs_level,
    input  logic fs_rise,
    output logic start,
    output logic long_mode
);
    localparam logic [WCNT_W-1:0] WMAX = '1;

    logic [WCNT_W-1:0] wcnt;
    logic              fs_prev;

    // Measure sync width and latch the timing style at the sync end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt      <= '0;
            fs_prev   <= 1'b0;
            long_mode <= 1'b0;
        end else if (bit_rise) begin
            fs_prev <= fs_level;
            if (fs_level) begin
                if (wcnt != WMAX) wcnt <= wcnt + 1'b1;
            end else if (fs_prev) begin
                long_mode <= (wcnt > WCNT_W'(1));
                wcnt      <= '0;
            end
        end
    end

    // Short start is immediate on a one-bit pulse; long start uses history.
    assign start = (bit_rise && fs_prev && !fs_level && wcnt == WCNT_W'(1))
                 || (fs_rise && long_mode);

    // R3
    long_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_rise |=> $stable(long_mode));
endmodule

// File: rtl/pcm_tx_shifter.sv
// Transmit shifter. It loads the sample at frame start (sign-extended to
// 16 bits in sign-extended mode, else left-justified) and moves one bit per
// bit-clock rise, MSB first. The output enable covers only the data bits.
module pcm_tx_shifter
    import pcm_port_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_rise,
    input  logic                start,
    input  port_mode_e          mode,
    input  logic [SAMPLE_W-1:0] sample,
    output logic                dout,
    output logic                oe
);
    logic [WORD_W-1:0] sh;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  last;
    logic              active;
    port_mode_e        mode_q;

    // Bit count of the current word depends on the captured mode.
    always_comb last = (mode_q == PORT_SIGNEXT) ? CNT_W'(WORD_W - 1) : CNT_W'(SAMPLE_W - 1);

    // Load on frame start, then shift until the last bit has been held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh     <= '0;
            cnt    <= '0;
            active <= 1'b0;
            mode_q <= PORT_ASYNC;
        end else if (start) begin
            active <= 1'b1;
            cnt    <= '0;
            mode_q <= mode;
            sh     <= (mode == PORT_SIGNEXT) ? {{ATTEN_W{sample[SAMPLE_W-1]}}, sample}
                                             : {sample, {ATTEN_W{1'b0}}};
        end else if (bit_rise && active) begin
            if (cnt == last) begin
                active <= 1'b0;
            end else begin
                sh  <= sh << 1;
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign oe   = active;
    assign dout = active & sh[WORD_W-1];

    // R4
    oe_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(start));
    // R2
    oe_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> $past(bit_rise));
endmodule

// File: rtl/pcm_rx_shifter.sv
// Receive shifter. After frame start it takes one bit per bit-clock fall,
// MSB first: 13 bits in asynchronous mode, 16 otherwise. It then splits the
// word by mode and strobes it out for one cycle.
module pcm_rx_shifter
    import pcm_port_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_fall,
    input  logic                start,
    input  port_mode_e          mode,
    input  logic                din,
    output logic [SAMPLE_W-1:0] sample,
    output logic [ATTEN_W-1:0]  atten,
    output logic                valid
);
    logic [WORD_W-1:0] sh;
    logic [WORD_W-1:0] nxt;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  last;
    logic              active;
    port_mode_e        mode_q;

    // Word after the current bit and the bit count of this frame.
    always_comb begin
        nxt  = {sh[WORD_W-2:0], din};
        last = (mode_q == PORT_ASYNC) ? CNT_W'(SAMPLE_W - 1) : CNT_W'(WORD_W - 1);
    end

    // Collect bits and publish the split word at the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh     <= '0;
            cnt    <= '0;
            active <= 1'b0;
            mode_q <= PORT_ASYNC;
            sample <= '0;
            atten  <= '0;
            valid  <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (start) begin
                active <= 1'b1;
                cnt    <= '0;
                mode_q <= mode;
            end else if (bit_fall && active) begin
                sh  <= nxt;
                cnt <= cnt + 1'b1;
                if (cnt == last) begin
                    active <= 1'b0;
                    valid  <= 1'b1;
                    sample <= (mode_q == PORT_GAINADJ) ? nxt[WORD_W-1 -: SAMPLE_W] : nxt[SAMPLE_W-1:0];
                    atten  <= (mode_q == PORT_GAINADJ) ? nxt[ATTEN_W-1:0] : '0;
                end
            end
        end
    end

    // R5
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);
endmodule

// File: rtl/pcm_mode_strap.sv
// Idle detector on the receive bit clock. It counts receive frame syncs
// with no bit-clock edge. At IDLE_FRAMES the clock is idle, and its resting
// level picks the synchronous mode. Any edge clears the count.
module pcm_mode_strap
    import pcm_port_pkg::*;
#(
    parameter int IDLE_FRAMES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bclk_edge,
    input  logic       bclk_level,
    input  logic       fs_rise,
    output logic       idle,
    output port_mode_e mode
);
    localparam int CW = $clog2(IDLE_FRAMES + 1);
    localparam logic [CW-1:0] QMAX = CW'(IDLE_FRAMES);

    logic [CW-1:0] quiet;

    // Count quiet frames, saturating at the idle threshold.
    always_ff @(posedge clk) begin
        if (!rst_n)                          quiet <= '0;
        else if (bclk_edge)                  quiet <= '0;
        else if (fs_rise && quiet != QMAX)   quiet <= quiet + 1'b1;
    end

    // Decode the idle flag and strap level into the port mode.
    always_comb begin
        idle = (quiet == QMAX);
        if (!idle)           mode = PORT_ASYNC;
        else if (bclk_level) mode = PORT_GAINADJ;
        else                 mode = PORT_SIGNEXT;
    end

    // R6
    edge_wakes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_edge |=> !idle);
    // R6
    idle_on_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle) |-> $past(fs_rise));
endmodule

// File: rtl/pcm_voice_port.sv
// Top level of the serial PCM port. It synchronizes the pad inputs, finds
// bit-clock and sync edges, and selects the receive bit clock from the
// strap state. It drives one transmit and one receive datapath, each with
// its own frame timing. Assumes bit clocks are slow against clk (at least
// a few system clocks per half period).
module pcm_voice_port
    import pcm_port_pkg::*;
#(
    parameter int IDLE_FRAMES = 4,
    parameter int SYNC_STAGES = 2,
    parameter int WCNT_W      = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tx_bclk,
    input  logic                tx_fsync,
    input  logic [SAMPLE_W-1:0] tx_sample,
    output logic                tx_dout,
    output logic                tx_oe,
    input  logic                rx_bclk,
    input  logic                rx_fsync,
    input  logic                rx_din,
    output logic [SAMPLE_W-1:0] rx_sample,
    output logic [ATTEN_W-1:0]  rx_atten,
    output logic                rx_valid,
    output logic [1:0]          port_mode
);
    localparam int NLINES = 5;   // tx_bclk, tx_fsync, rx_bclk, rx_fsync, rx_din
    localparam int NEDGE  = 4;   // lines that need edge detection

    logic [NLINES-1:0] lines;
    logic [NEDGE-1:0]  prev;
    logic tx_br, tx_bf, tx_fr, rxb_edge, rxb_rise, rxb_fall, rx_fr;
    logic rx_br, rx_bf, idle, tx_start, rx_start, tx_long, rx_long;
    port_mode_e mode;

    pcm_input_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({rx_din, rx_fsync, rx_bclk, tx_fsync, tx_bclk}), .q(lines));

    // Hold the previous synchronized level of the clock and sync lines.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= lines[NEDGE-1:0];
    end

    // Edge events and the receive clock choice.
    always_comb begin
        tx_br    =  lines[0] & ~prev[0];
        tx_bf    = ~lines[0] &  prev[0];
        tx_fr    =  lines[1] & ~prev[1];
        rxb_rise =  lines[2] & ~prev[2];
        rxb_fall = ~lines[2] &  prev[2];
        rxb_edge =  lines[2] ^  prev[2];
        rx_fr    =  lines[3] & ~prev[3];
        rx_br    = idle ? tx_br : rxb_rise;
        rx_bf    = idle ? tx_bf : rxb_fall;
    end

    pcm_mode_strap #(.IDLE_FRAMES(IDLE_FRAMES)) u_strap (
        .clk(clk), .rst_n(rst_n), .bclk_edge(rxb_edge), .bclk_level(lines[2]),
        .fs_rise(rx_fr), .idle(idle), .mode(mode));

    pcm_frame_timing #(.WCNT_W(WCNT_W)) u_tx_frame (
        .clk(clk), .rst_n(rst_n), .bit_rise(tx_br), .fs_level(lines[1]),
        .fs_rise(tx_fr), .start(tx_start), .long_mode(tx_long));

    pcm_frame_timing #(.WCNT_W(WCNT_W)) u_rx_frame (
        .clk(clk), .rst_n(rst_n), .bit_rise(rx_br), .fs_level(lines[3]),
        .fs_rise(rx_fr), .start(rx_start), .long_mode(rx_long));

    pcm_tx_shifter u_tx (
        .clk(clk), .rst_n(rst_n), .bit_rise(tx_br), .start(tx_start),
        .mode(mode), .sample(tx_sample), .dout(tx_dout), .oe(tx_oe));

    pcm_rx_shifter u_rx (
        .clk(clk), .rst_n(rst_n), .bit_fall(rx_bf), .start(rx_start),
        .mode(mode), .din(lines[4]), .sample(rx_sample), .atten(rx_atten),
        .valid(rx_valid));

    assign port_mode = mode;

    // R3
    tx_long_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_fr && !tx_long) |-> !tx_start);
    // R3
    rx_long_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_fr && !rx_long && !rx_br) |-> !rx_start);
endmodule

// File: tb/tb_pcm_voice_port.sv
`timescale 1ns/1ps
module tb_pcm_voice_port;
    localparam int HB     = 8;    // system clocks per bit-clock half period
    localparam int NPER   = 24;   // bit periods per bench frame

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_bclk = 0, tx_fsync = 0, rx_bclk = 0, rx_fsync = 0, rx_din = 0;
    logic [12:0] tx_sample = '0;
    logic tx_dout, tx_oe, rx_valid;
    logic [12:0] rx_sample;
    logic [2:0]  rx_atten;
    logic [1:0]  port_mode;

    int total = 0, fails = 0, vcount = 0;
    logic [12:0] cap_s;
    logic [2:0]  cap_a;
    logic [NPER-1:0] obs_oe, obs_dout;

    pcm_voice_port dut (
        .clk(clk), .rst_n(rst_n), .tx_bclk(tx_bclk), .tx_fsync(tx_fsync),
        .tx_sample(tx_sample), .tx_dout(tx_dout), .tx_oe(tx_oe),
        .rx_bclk(rx_bclk), .rx_fsync(rx_fsync), .rx_din(rx_din),
        .rx_sample(rx_sample), .rx_atten(rx_atten), .rx_valid(rx_valid),
        .port_mode(port_mode));

    always #2 clk = ~clk;   // 250 MHz

    // Capture receive strobes away from the active edge.
    always @(negedge clk) begin
        if (rx_valid) begin
            vcount <= vcount + 1;
            cap_s  <= rx_sample;
            cap_a  <= rx_atten;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic fs_at(int q, bit lng);
        return lng ? (q >= 0 && q < 8) : (q == 0);
    endfunction

    function automatic int tx_len(int mode); return (mode == 1) ? 16 : 13; endfunction
    function automatic int rx_len(int mode); return (mode == 0) ? 13 : 16; endfunction

    function automatic logic rx_bit(int q, bit lng, int len, logic [15:0] w);
        int j = q - (lng ? 0 : 1);
        if (j >= 0 && j < len) return w[len-1-j];
        return 1'b0;
    endfunction

    function automatic logic [NPER-1:0] exp_oe(int mode, bit lng);
        logic [NPER-1:0] v = '0;
        int off = lng ? 0 : 1;
        for (int p = 0; p < NPER; p++) v[p] = (p >= off) && (p < off + tx_len(mode));
        return v;
    endfunction

    function automatic logic [NPER-1:0] exp_dout(int mode, bit lng, logic [12:0] s);
        logic [NPER-1:0] v = '0;
        logic [15:0] w = (mode == 1) ? {{3{s[12]}}, s} : {s, 3'b000};
        int off = lng ? 0 : 1;
        for (int j = 0; j < tx_len(mode); j++) v[off+j] = w[15-j];
        return v;
    endfunction

    // Drive one bench frame: transmit sync at period 0, receive sync at rs.
    task automatic run_frame(input bit lng, input int rs, input int mode,
                             input logic [12:0] txs, input logic [15:0] rxw,
                             input bit rx_on, input bit strap);
        tx_sample = txs;
        vcount = 0;
        for (int p = 0; p < NPER; p++) begin
            @(negedge clk);
            tx_bclk  = 1'b1;
            rx_bclk  = rx_on ? 1'b1 : strap;
            tx_fsync = fs_at(p, lng);
            rx_fsync = fs_at(p - rs, lng);
            rx_din   = rx_bit(p - rs, lng, rx_len(mode), rxw);
            repeat (5) @(negedge clk);
            obs_oe[p]   = tx_oe;
            obs_dout[p] = tx_dout;
            repeat (HB - 5) @(negedge clk);
            tx_bclk = 1'b0;
            if (rx_on) rx_bclk = 1'b0;
            repeat (HB - 1) @(negedge clk);
        end
    endtask

    task automatic check_frame(input int mode, input bit lng, input logic [12:0] txs,
                               input logic [15:0] rxw, input string rtx, input string rrx);
        logic [12:0] es = (mode == 2) ? rxw[15:3] : rxw[12:0];
        logic [2:0]  ea = (mode == 2) ? rxw[2:0] : 3'b000;
        check(obs_oe == exp_oe(mode, lng), rtx, 32'(obs_oe), 32'(exp_oe(mode, lng)));
        check(obs_dout == exp_dout(mode, lng, txs), rtx, 32'(obs_dout), 32'(exp_dout(mode, lng, txs)));
        check(vcount == 1 && cap_s == es && cap_a == ea, rrx,
              {3'(vcount), cap_a, 13'd0, cap_s}, {3'd1, ea, 13'd0, es});
    endtask

    task automatic rand_frame(input bit lng, input int mode, input bit rx_on,
                              input bit strap, input string rtx, input string rrx);
        logic [12:0] s = 13'($urandom);
        logic [15:0] w = 16'($urandom);
        int rs = int'($urandom % 4);
        run_frame(lng, rs, mode, s, w, rx_on, strap);
        check_frame(mode, lng, s, w, rtx, rrx);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        void'($urandom(32'd5120));
        repeat (6) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 reset state
        check(tx_oe == 0 && tx_dout == 0, "R1 tx", {tx_oe, tx_dout}, 0);
        check(rx_valid == 0, "R1 rx_valid", 32'(rx_valid), 0);
        check(port_mode == 0, "R1 port_mode", 32'(port_mode), 0);

        // R2 R5 R9: short frames, asynchronous mode, random offsets
        for (int i = 0; i < 6; i++) rand_frame(0, 0, 1, 0, "R2 R4 tx", "R5 R9 rx");
        run_frame(0, 0, 0, 13'h1000, 16'h1FFF, 1, 0);
        check_frame(0, 0, 13'h1000, 16'h1FFF, "R2 R4 tx neg full", "R5 rx ones");
        run_frame(0, 3, 0, 13'h0FFF, 16'h0000, 1, 0);
        check_frame(0, 0, 13'h0FFF, 16'h0000, "R2 R4 tx pos full", "R5 R9 rx zeros");

        // R3: first long frame only measured, later ones start at sync
        run_frame(1, 0, 0, 13'h1555, 16'h0AAA, 1, 0);
        check(obs_oe == 0, "R3 measure frame tx_oe", 32'(obs_oe), 0);
        check(vcount == 0, "R3 measure frame rx_valid", 32'(vcount), 0);
        for (int i = 0; i < 4; i++) rand_frame(1, 0, 1, 0, "R3 R4 tx long", "R3 R9 rx long");

        // back to short timing (frame with timing change not checked)
        run_frame(0, 0, 0, 13'h0, 16'h0, 1, 0);

        // R6: idle boundary with strap level 0
        for (int k = 1; k <= 4; k++) begin
            run_frame(0, 0, 0, 13'($urandom), 16'h0, 0, 0);
            check(port_mode == ((k < 4) ? 2'd0 : 2'd1), "R6 idle count",
                  32'(port_mode), (k < 4) ? 0 : 1);
        end
        // R7: sign-extended transfers on the transmit bit clock
        run_frame(0, 2, 1, 13'h1234, 16'hFC21, 0, 0);
        check_frame(1, 0, 13'h1234, 16'hFC21, "R7 tx sign", "R7 rx");
        for (int i = 0; i < 3; i++) rand_frame(0, 1, 0, 0, "R7 tx", "R7 R9 rx");

        // R6 R8: strap level 1 selects gain-adjust
        for (int k = 0; k < 5; k++) run_frame(0, 0, 2, 13'h0, 16'h0, 0, 1);
        check(port_mode == 2, "R6 strap high", 32'(port_mode), 2);
        run_frame(0, 1, 2, 13'h0ABC, 16'hFFF5, 0, 1);
        check_frame(2, 0, 13'h0ABC, 16'hFFF5, "R8 tx", "R8 rx atten");
        for (int i = 0; i < 3; i++) rand_frame(0, 2, 0, 1, "R8 tx", "R8 R9 rx");

        // R6: resumed receive clock returns to asynchronous mode
        run_frame(0, 0, 0, 13'h0, 16'h0, 1, 0);
        check(port_mode == 0, "R6 wake", 32'(port_mode), 0);
        for (int i = 0; i < 2; i++) rand_frame(0, 0, 1, 0, "R2 tx after wake", "R5 rx after wake");

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule